// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, in both directions. It passes data through unchanged. Each direction has its own path. The forward path carries data from A to B and the reverse path carries data from B to A. Each path has a load strobe, a register that the strobe fills, a source pick and a drive enable. The two drive enables have opposite polarity: the forward enable is active high and the reverse enable is active low. A path that is enabled drives one of two values. It drives the live value of the opposite bus when its pick is low, or its own stored word when its pick is high.

Each bus appears at the port as three signals: an input, an output and a one-bit drive flag. The surrounding logic, which in this project is the testbench, resolves the bus. Each path works in one of three modes: OFF (not driving), LIVE (passing the opposite bus through) and STORED (driving the register). The mode is decoded from the path's enable and pick on every cycle, and any mode can follow any other.

A register loads on the clock edge whenever its strobe is high, whatever the enables and picks are. Some useful cases follow from this:
- Both paths in STORED at once exchange the two stored words.
- Loading both registers while one path is in LIVE copies a single bus into both registers.
- Both paths in LIVE with no other driver keep each bus at its last value.

Top module: `dual_path_transceiver`

## Requirements
- R1: With fwd_drive=1 and fwd_use_reg=0, b_out equals a_in in the same cycle, bit for bit and not inverted.
- R2: With rev_drive_n=0 and rev_use_reg=0, a_out equals b_in in the same cycle, bit for bit and not inverted.
- R3: b_drive is 1 exactly when fwd_drive is 1. b_out is only meaningful while b_drive is 1.
- R4: a_drive is 1 exactly when rev_drive_n is 0. a_out is only meaningful while a_drive is 1.
- R5: On a rising clk edge with fwd_load=1, the forward register takes a_in. Without the strobe it holds its value. With fwd_drive=1 and fwd_use_reg=1, b_out shows the forward register.
- R6: On a rising clk edge with rev_load=1, the reverse register takes b_in. Without the strobe it holds its value. With rev_drive_n=0 and rev_use_reg=1, a_out shows the reverse register.
- R7: Loading happens whatever values fwd_drive, rev_drive_n, fwd_use_reg and rev_use_reg have, including when both buses are isolated.
- R8: With fwd_drive=1, rev_drive_n=0 and both picks at 1, a_out shows the reverse register and b_out shows the forward register at the same time.
- R9: While rst_n is 0, both registers are cleared to zero at once, without waiting for a clock edge.
- R10: With the forward path in LIVE and the reverse path off, strobing both loads puts the A value into both registers. With the reverse path in LIVE and the forward path off, strobing both loads puts the B value into both registers.
- R11: With both paths in LIVE and no other driver, each output equals the opposite input, so the resolved buses keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both registers |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| fwd_load | input | 1 | Forward register loads a_in on the next rising edge |
| rev_load | input | 1 | Reverse register loads b_in on the next rising edge |
| fwd_drive | input | 1 | Forward drive enable, active high |
| rev_drive_n | input | 1 | Reverse drive enable, active low |
| fwd_use_reg | input | 1 | Forward source pick: 0 = live A, 1 = forward register |
| rev_use_reg | input | 1 | Reverse source pick: 0 = live B, 1 = reverse register |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value this block drives onto bus A |
| a_drive | output | 1 | This block is driving bus A |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value this block drives onto bus B |
| b_drive | output | 1 | This block is driving bus B |

## Verification
The drive flags and the LIVE outputs are combinational. They are due in the same cycle as the change of enable, pick or opposite input. A word loaded on a rising edge appears on a STORED output from that edge onward, and reset clears the registers without any edge. The bench changes its inputs at the falling edge and resolves both buses from its own register model. It checks the outputs 2 ns later. It moves its register model forward only at the rising edge, so every loaded word is first compared in the following cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_LIVE   = 2'd1,
        PATH_STORED = 2'd2
    } path_mode_e;
endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R5 R6
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R5 R6
    no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (q == '0);
        end
    end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W        = 8,
    parameter bit EN_LOW   = 1'b0
) (
    input  logic         en,
    input  logic         use_reg,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] out,
    output logic         drive
);
    logic       en_act;
    path_mode_e mode;

    generate
        if (EN_LOW) begin : g_low
            assign en_act = ~en;
        end else begin : g_high
            assign en_act = en;
        end
    endgenerate

    always_comb begin
        if (!en_act) begin
            mode = PATH_OFF;
        end else if (use_reg) begin
            mode = PATH_STORED;
        end else begin
            mode = PATH_LIVE;
        end
    end

    always_comb begin
        unique case (mode)
            PATH_OFF: begin
                out   = '0;
                drive = 1'b0;
            end
            PATH_LIVE: begin
                out   = live;
                drive = 1'b1;
            end
            PATH_STORED: begin
                out   = held;
                drive = 1'b1;
            end
            default: begin
                out   = '0;
                drive = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dual_path_transceiver.sv
module dual_path_transceiver #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fwd_load,
    input  logic         rev_load,
    input  logic         fwd_drive,
    input  logic         rev_drive_n,
    input  logic         fwd_use_reg,
    input  logic         rev_use_reg,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive
);
    logic [W-1:0] fwd_q;
    logic [W-1:0] rev_q;

    xcvr_hold_reg #(.W(W)) u_fwd_reg (
        .clk(clk), .rst_n(rst_n), .load(fwd_load), .d(a_in), .q(fwd_q)
    );

    xcvr_hold_reg #(.W(W)) u_rev_reg (
        .clk(clk), .rst_n(rst_n), .load(rev_load), .d(b_in), .q(rev_q)
    );

    xcvr_path #(.W(W), .EN_LOW(1'b0)) u_fwd_path (
        .en(fwd_drive), .use_reg(fwd_use_reg), .live(a_in), .held(fwd_q),
        .out(b_out), .drive(b_drive)
    );

    xcvr_path #(.W(W), .EN_LOW(1'b1)) u_rev_path (
        .en(rev_drive_n), .use_reg(rev_use_reg), .live(b_in), .held(rev_q),
        .out(a_out), .drive(a_drive)
    );

    // R3
    b_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_drive == fwd_drive);

    // R4
    a_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive == !rev_drive_n);

    // R1
    fwd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_drive && !fwd_use_reg) |-> (b_out == a_in));

    // R8
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_drive && !rev_drive_n && fwd_use_reg && rev_use_reg)
        |-> (a_out == rev_q && b_out == fwd_q));
endmodule

// File: tb/dual_path_transceiver_bench.sv
module dual_path_transceiver_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fwd_load = 1'b0, rev_load = 1'b0;
    logic         fwd_drive = 1'b0, rev_drive_n = 1'b1;
    logic         fwd_use_reg = 1'b0, rev_use_reg = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_fwd = '0, m_rev = '0;
    logic [W-1:0] a_keep = '0, b_keep = '0;

    always #10 clk = ~clk;

    dual_path_transceiver #(.W(W)) u_dual_path_transceiver (
        .clk(clk), .rst_n(rst_n), .fwd_load(fwd_load), .rev_load(rev_load),
        .fwd_drive(fwd_drive), .rev_drive_n(rev_drive_n),
        .fwd_use_reg(fwd_use_reg), .rev_use_reg(rev_use_reg),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
    );

    task automatic expect_eq(input string tag, input string what,
                             input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_ports(input string extra);
        logic exp_bd, exp_ad;
        exp_bd = fwd_drive;
        exp_ad = !rev_drive_n;
        expect_eq({"R3 ", extra}, "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, exp_bd});
        expect_eq({"R4 ", extra}, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, exp_ad});
        if (exp_bd)
            expect_eq({fwd_use_reg ? "R5 " : "R1 ", extra}, "b_out", b_out,
                      fwd_use_reg ? m_fwd : a_in);
        if (exp_ad)
            expect_eq({rev_use_reg ? "R6 " : "R2 ", extra}, "a_out", a_out,
                      rev_use_reg ? m_rev : b_in);
    endtask

    // One cycle: set controls at the falling edge, resolve both buses, check, then advance model.
    task automatic cyc(input logic fl, input logic rl, input logic fd, input logic rdn,
                       input logic fu, input logic ru,
                       input logic ea_en, input logic [W-1:0] ea,
                       input logic eb_en, input logic [W-1:0] eb,
                       input string extra);
        logic a_dev, b_dev, a_fix, b_fix;
        logic [W-1:0] av, bv;
        @(negedge clk);
        fwd_load = fl; rev_load = rl; fwd_drive = fd; rev_drive_n = rdn;
        fwd_use_reg = fu; rev_use_reg = ru;
        a_dev = !rdn; b_dev = fd;
        a_fix = 1'b0; b_fix = 1'b0; av = a_keep; bv = b_keep;
        if (ea_en) begin av = ea; a_fix = 1'b1; end
        else if (a_dev && ru) begin av = m_rev; a_fix = 1'b1; end
        else if (!a_dev) begin av = a_keep; a_fix = 1'b1; end
        if (eb_en) begin bv = eb; b_fix = 1'b1; end
        else if (b_dev && fu) begin bv = m_fwd; b_fix = 1'b1; end
        else if (!b_dev) begin bv = b_keep; b_fix = 1'b1; end
        if (!a_fix && b_fix) begin av = bv; a_fix = 1'b1; end
        if (!b_fix && a_fix) begin bv = av; b_fix = 1'b1; end
        if (!a_fix && !b_fix) begin av = a_keep; bv = b_keep; end
        a_keep = av; b_keep = bv;
        a_in = av; b_in = bv;
        #2;
        check_ports(extra);
        @(posedge clk);
        if (rst_n) begin
            if (fl) m_fwd = av;
            if (rl) m_rev = bv;
        end
    endtask

    initial begin
        #150000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: reset holds both registers at zero, seen in STORED on both paths
        cyc(1, 1, 1, 0, 1, 1, 0, '0, 0, '0, "R9 reset");
        cyc(0, 0, 1, 0, 1, 1, 0, '0, 0, '0, "R9 reset");
        @(negedge clk); rst_n = 1'b1;
        // R1 live forward, R2 live reverse
        cyc(0, 0, 1, 1, 0, 0, 1, 8'h5A, 0, '0, "live fwd");
        cyc(0, 0, 0, 0, 0, 0, 0, '0, 1, 8'hC3, "live rev");
        // R7: load forward while isolated, then read back
        cyc(1, 0, 0, 1, 0, 0, 1, 8'h3C, 1, 8'h11, "R7 load isolated");
        cyc(0, 0, 1, 1, 1, 0, 1, 8'hFF, 0, '0, "R7 readback");
        // R6: load reverse while the A side drives stored data
        cyc(0, 1, 0, 0, 1, 1, 0, '0, 1, 8'h96, "R7 rev load");
        cyc(0, 0, 0, 0, 0, 1, 0, '0, 1, 8'h01, "rev hold");
        cyc(0, 0, 1, 1, 1, 0, 1, 8'h02, 0, '0, "fwd hold");
        // R8: both stored words swap onto opposite buses
        cyc(0, 0, 1, 0, 1, 1, 0, '0, 0, '0, "R8 swap");
        // R10: forward live copies A into both registers
        cyc(1, 1, 1, 1, 0, 0, 1, 8'h77, 0, '0, "R10 both A");
        cyc(0, 0, 1, 0, 1, 1, 0, '0, 0, '0, "R10 both A read");
        // R10: reverse live copies B into both registers
        cyc(1, 1, 0, 0, 0, 0, 0, '0, 1, 8'h21, "R10 both B");
        cyc(0, 0, 1, 0, 1, 1, 0, '0, 0, '0, "R10 both B read");
        // R11: both LIVE with no other driver keep the bus values
        cyc(0, 0, 1, 1, 0, 0, 1, 8'h4E, 0, '0, "R11 prime");
        cyc(0, 0, 1, 0, 0, 0, 0, '0, 0, '0, "R11 loop");
        cyc(1, 1, 1, 0, 0, 0, 0, '0, 0, '0, "R11 loop load");
        cyc(0, 0, 1, 0, 1, 1, 0, '0, 0, '0, "R11 loop read");
        // mixed patterns, external drivers only on undriven buses
        for (int i = 0; i < 60; i++) begin
            logic [7:0] r;
            logic fd_r, rdn_r;
            r = 8'($urandom);
            fd_r = r[2]; rdn_r = r[3];
            cyc(r[0], r[1], fd_r, rdn_r, r[4], r[5], rdn_r, 8'($urandom),
                !fd_r, 8'($urandom), "R7 mixed");
        end
        // R9: asynchronous clear in mid-cycle
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        m_fwd = '0; m_rev = '0;
        fwd_drive = 1'b1; rev_drive_n = 1'b0; fwd_use_reg = 1'b1; rev_use_reg = 1'b1;
        #1;
        expect_eq("R9 async", "b_out", b_out, '0);
        expect_eq("R9 async", "a_out", a_out, '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule